// File: doc/BRIEF.md
# External Memory Address Remapper

This block sits in front of a code cache and translates fetch addresses. Each access that arrives on the input is compared against a small set of programmable regions inside the code address space. When an enabled region claims the address, the upper address bits are swapped for the region's target so the access lands in an external memory window. The block also reports which master port should carry the access (fast internal or slow external) and whether the burst should wrap or increment. Addresses that no region claims leave unchanged on the fast port.

Each region is programmed with a single configuration word through a write port. The word holds an 8-bit base (address bits 28..21), a 3-bit size code, an 11-bit target (address bits 31..21), a port bit, a burst bit and an enable bit. Translation does not depend on whether the access is cacheable, and so it does not depend on whether a cache behind the block is active. The cacheability attribute travels with the access and is not used for the decision. Results are registered, so every output appears one clock after its access.

Top module: `remap_unit`

## Requirements
- R1: After reset every region is disabled and all outputs are 0, so any access then leaves untranslated.
- R2: `out_valid` is high exactly one cycle after `in_valid` was high, and all other outputs belong to that same access.
- R3: When `cfg_we` is 1, `cfg_wdata` is stored as the word of region `cfg_sel`. It takes effect for accesses presented from the next cycle on. Word layout: bits 7..0 base, 10..8 size code, 21..11 target, bit 22 port select, bit 23 burst select, bit 24 enable.
- R4: A region spans 1 MB shifted left by its size code, so code 0 is 1 MB and code 7 is 128 MB.
- R5: An address matches a region when all its bits at and above log2(region size) equal the same bits of {3'b000, base, 21 zero bits}.
- R6: On a match, the output address takes the bits at and above the size boundary from {target, 21 zero bits} and keeps the offset bits below the boundary.
- R7: On a match, `out_port` equals the region's port bit (1 = slow external port) and `out_burst` equals its burst bit (0 = wrapping, 1 = incrementing). `out_hit` is 1 and `out_region` gives the region index.
- R8: With no match, `out_addr` equals the input address, `out_port` is 0 (fast), `out_burst` is 1, `out_hit` is 0 and `out_region` is 0.
- R9: When more than one enabled region matches, the lowest-numbered one decides.
- R10: A region whose enable bit is 0 never matches.
- R11: A region whose aligned base lies in 0x0800_0000 to 0x0FFF_FFFF never matches. Only the windows 0x0000_0000 to 0x07FF_FFFF and 0x1000_0000 to 0x1FFF_FFFF can be remapped.
- R12: `in_cacheable` has no effect on translation and is forwarded to `out_cacheable` with the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a region word |
| cfg_sel | input | 2 | Region index to write |
| cfg_wdata | input | 25 | Region configuration word |
| in_valid | input | 1 | Access present |
| in_addr | input | 32 | Access address |
| in_cacheable | input | 1 | Cacheability attribute of the access |
| out_valid | output | 1 | Translated access present |
| out_addr | output | 32 | Translated address |
| out_port | output | 1 | Master port: 0 fast, 1 slow |
| out_burst | output | 1 | Burst type: 0 wrapping, 1 incrementing |
| out_hit | output | 1 | A region claimed the access |
| out_region | output | 2 | Index of the claiming region |
| out_cacheable | output | 1 | Forwarded cacheability attribute |

## Verification
The bench probes the last words inside a region and the first word past it, at both the 1 MB and the 128 MB size. A mask off by one bit would either translate an outside address or split the offset. It overlaps two regions with different targets: a design with the priority reversed sends the shared addresses to the wrong window. It then disables the winning region and checks that the loser takes over. It places a region in the forbidden 0x08xx_xxxx window and sends an address above the code space. A missing window check or missing upper-bit compare would translate these addresses instead of passing them through. Cacheable and non-cacheable accesses are mixed through the vectors, which catches any gating of translation by the attribute.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int ADDR_W     = 32;
    localparam int BASE_LSB   = 21;
    localparam int BASE_W     = 8;
    localparam int TGT_W      = ADDR_W - BASE_LSB;
    localparam int SIZE_W     = 3;
    localparam int MIN_LOG2   = 20;
    localparam int HOLE_BIT   = 27;
    localparam int SHIFT_W    = $clog2(ADDR_W);

    typedef struct packed {
        logic               en;
        logic               burst;
        logic               port;
        logic [TGT_W-1:0]   target;
        logic [SIZE_W-1:0]  size;
        logic [BASE_W-1:0]  base;
    } region_cfg_t;

    localparam int CFG_W = $bits(region_cfg_t);
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
    import remap_pkg::*;
#(
    parameter int N_REGIONS = 4,
    localparam int IDX_W = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_sel,
    input  logic [CFG_W-1:0]  wr_data,
    output region_cfg_t       cfg_o [N_REGIONS]
);
    region_cfg_t cfg_d [N_REGIONS];
    region_cfg_t cfg_q [N_REGIONS];

    always_comb begin
        for (int i = 0; i < N_REGIONS; i++) begin
            cfg_d[i] = cfg_q[i];
            if (wr_en && (int'(wr_sel) == i)) begin
                cfg_d[i] = region_cfg_t'(wr_data);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGIONS; i++) cfg_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_REGIONS; i++) cfg_q[i] <= cfg_d[i];
        end
    end

    assign cfg_o = cfg_q;

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_chk
        AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_sel) == g) |=> (cfg_q[g] == $past(wr_data))); // R3
        AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en) |=> $stable(cfg_q[g])); // R3
    end
endmodule

// File: rtl/remap_region_match.sv
module remap_region_match
    import remap_pkg::*;
(
    input  region_cfg_t        cfg,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [ADDR_W-1:0]  xlat_addr
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [SHIFT_W-1:0] bound;
    logic [ADDR_W-1:0]  lo_mask;
    logic [ADDR_W-1:0]  base_full;
    logic [ADDR_W-1:0]  tgt_full;
    logic [ADDR_W-1:0]  base_aligned;
    logic               legal;

    always_comb begin
        bound        = SHIFT_W'(MIN_LOG2) + SHIFT_W'(cfg.size);
        lo_mask      = (ONE << bound) - ONE;
        base_full    = {{(ADDR_W-BASE_LSB-BASE_W){1'b0}}, cfg.base, {BASE_LSB{1'b0}}};
        tgt_full     = {cfg.target, {BASE_LSB{1'b0}}};
        base_aligned = base_full & ~lo_mask;
        legal        = base_aligned[HOLE_BIT+1] | ~base_aligned[HOLE_BIT];
        hit          = cfg.en && legal && ((addr & ~lo_mask) == base_aligned);
        xlat_addr    = (tgt_full & ~lo_mask) | (addr & lo_mask);
    end
endmodule

// File: rtl/remap_unit.sv
module remap_unit
    import remap_pkg::*;
#(
    parameter int N_REGIONS = 4,
    localparam int IDX_W = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_cacheable,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_port,
    output logic              out_burst,
    output logic              out_hit,
    output logic [IDX_W-1:0]  out_region,
    output logic              out_cacheable
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              port;
        logic              burst;
        logic              hit;
        logic [IDX_W-1:0]  region;
        logic              cacheable;
    } out_t;

    region_cfg_t       cfg      [N_REGIONS];
    logic              hit_vec  [N_REGIONS];
    logic [ADDR_W-1:0] xlat_vec [N_REGIONS];
    logic              any_hit;
    out_t              out_d, out_q;

    remap_cfg_regs #(.N_REGIONS(N_REGIONS)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .cfg_o   (cfg)
    );

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
        remap_region_match match_i (
            .cfg       (cfg[g]),
            .addr      (in_addr),
            .hit       (hit_vec[g]),
            .xlat_addr (xlat_vec[g])
        );
    end

    always_comb begin
        out_d           = '0;
        out_d.valid     = in_valid;
        out_d.cacheable = in_cacheable;
        out_d.addr      = in_addr;
        out_d.burst     = 1'b1;
        any_hit         = 1'b0;
        // Walk from the top so the lowest index is written last and wins
        for (int i = N_REGIONS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit      = 1'b1;
                out_d.hit    = 1'b1;
                out_d.region = IDX_W'(i);
                out_d.addr   = xlat_vec[i];
                out_d.port   = cfg[i].port;
                out_d.burst  = cfg[i].burst;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid     = out_q.valid;
    assign out_addr      = out_q.addr;
    assign out_port      = out_q.port;
    assign out_burst     = out_q.burst;
    assign out_hit       = out_q.hit;
    assign out_region    = out_q.region;
    assign out_cacheable = out_q.cacheable;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid))); // R2
    AST_ATTR_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_cacheable == $past(in_cacheable))); // R12
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_addr[MIN_LOG2-1:0] == $past(in_addr[MIN_LOG2-1:0]))); // R6
    AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_hit) |=> (out_addr == $past(in_addr) && !out_hit && !out_port)); // R8
    AST_HIT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_hit) |=> out_hit); // R7
endmodule

// File: tb/remap_unit_tb_top.sv
module remap_unit_tb_top;
    import remap_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_addr = '0;
    logic              in_cacheable = 1'b0;
    logic              out_valid, out_port, out_burst, out_hit, out_cacheable;
    logic [31:0]       out_addr;
    logic [1:0]        out_region;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    remap_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr),
        .in_cacheable(in_cacheable), .out_valid(out_valid), .out_addr(out_addr),
        .out_port(out_port), .out_burst(out_burst), .out_hit(out_hit),
        .out_region(out_region), .out_cacheable(out_cacheable)
    );

    // Vector: {addr, cacheable, exp_addr, exp_hit, exp_region, exp_port, exp_burst}
    localparam int NV = 11;
    localparam logic [69:0] VEC [NV] = '{
        {32'h1000_0004, 1'b1, 32'h9000_0004, 1'b1, 2'd0, 1'b1, 1'b0},
        {32'h107F_FFFC, 1'b0, 32'h907F_FFFC, 1'b1, 2'd0, 1'b1, 1'b0},
        {32'h1080_0000, 1'b1, 32'h6080_0000, 1'b1, 2'd1, 1'b0, 1'b1},
        {32'h10FF_FFF0, 1'b0, 32'h60FF_FFF0, 1'b1, 2'd1, 1'b0, 1'b1},
        {32'h1100_0000, 1'b1, 32'h1100_0000, 1'b0, 2'd0, 1'b0, 1'b1},
        {32'h0001_2345, 1'b0, 32'hA001_2345, 1'b1, 2'd2, 1'b1, 1'b1},
        {32'h000F_FFFF, 1'b1, 32'hA00F_FFFF, 1'b1, 2'd2, 1'b1, 1'b1},
        {32'h0010_0000, 1'b1, 32'h0010_0000, 1'b0, 2'd0, 1'b0, 1'b1},
        {32'h0800_1000, 1'b1, 32'h0800_1000, 1'b0, 2'd0, 1'b0, 1'b1},
        {32'h9000_0000, 1'b0, 32'h9000_0000, 1'b0, 2'd0, 1'b0, 1'b1},
        {32'h0FFF_FFFC, 1'b0, 32'h0FFF_FFFC, 1'b0, 2'd0, 1'b0, 1'b1}
    };

    function automatic logic [CFG_W-1:0] word(input logic en, input logic burst,
            input logic port, input logic [10:0] tgt, input logic [2:0] size,
            input logic [7:0] base);
        return {en, burst, port, tgt, size, base};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] sel, input logic [CFG_W-1:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic c);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_cacheable = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [31:0] a, input logic c,
            input logic h, input logic [1:0] r, input logic p, input logic b);
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " addr"}, out_addr, a);
        chk({req, " hit"}, 32'(out_hit), 32'(h));
        chk({req, " region"}, 32'(out_region), 32'(r));
        chk({req, " port"}, 32'(out_port), 32'(p));
        chk({req, " burst"}, 32'(out_burst), 32'(b));
        chk({req, " cacheable R12"}, 32'(out_cacheable), 32'(c));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 addr", out_addr, 0);
        chk("R1 hit", 32'(out_hit), 0);
        rst_n = 1'b1;
        // R1: nothing programmed, address passes
        access(32'h1000_0004, 1'b1);
        expect_out("R1 unprogrammed", 32'h1000_0004, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1);
        // R2: no access -> no output
        @(negedge clk);
        chk("R2 idle", 32'(out_valid), 0);

        // R3 layout programming
        write_cfg(2'd0, word(1'b1, 1'b0, 1'b1, 11'h480, 3'd3, 8'h80));
        write_cfg(2'd1, word(1'b1, 1'b1, 1'b0, 11'h300, 3'd4, 8'h80));
        write_cfg(2'd2, word(1'b1, 1'b1, 1'b1, 11'h500, 3'd0, 8'h00));
        write_cfg(2'd3, word(1'b1, 1'b0, 1'b0, 11'h600, 3'd2, 8'h40)); // R11 window

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][69:38], VEC[i][37]);
            expect_out($sformatf("R3 R4 R5 R6 R7 R8 R9 R11 vec%0d", i), VEC[i][36:5],
                       VEC[i][37], VEC[i][4], VEC[i][3:2], VEC[i][1], VEC[i][0]);
        end

        // R10: disable region 0, region 1 takes over
        write_cfg(2'd0, word(1'b0, 1'b0, 1'b1, 11'h480, 3'd3, 8'h80));
        access(32'h1000_0004, 1'b0);
        expect_out("R10 disabled", 32'h6000_0004, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1);

        // R4: 128 MB region at 0
        write_cfg(2'd3, word(1'b1, 1'b0, 1'b0, 11'h400, 3'd7, 8'h00));
        access(32'h07FF_FFF0, 1'b1);
        expect_out("R4 size7", 32'h87FF_FFF0, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0);
        access(32'h0800_0000, 1'b1);
        expect_out("R4 size7 edge", 32'h0800_0000, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1);
        // R9: region 2 still wins inside its 1 MB
        access(32'h0000_0010, 1'b0);
        expect_out("R9 overlap", 32'hA000_0010, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1);

        // R2 back to back accesses
        @(negedge clk);
        in_valid = 1'b1; in_addr = 32'h0123_4560; in_cacheable = 1'b1;
        @(negedge clk);
        chk("R2 first", out_addr, 32'h8123_4560);
        in_addr = 32'h0000_0020; in_cacheable = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 second", out_addr, 32'hA000_0020);
        chk("R2 second cacheable R12", 32'(out_cacheable), 0);
        @(negedge clk);
        chk("R2 drop", 32'(out_valid), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule